// File: doc/BRIEF.md
# Two-Group Masked Interrupt Controller

This block gathers twenty-two interrupt request lines and turns them into two active-low requests for a processor: a normal request and a fast request. Every source belongs to one group, fixed at design time. Sources 0 to 16 are normal and sources 17 to 21 are fast. Each source also has an enable bit in a mask register. A group output goes low when any enabled source in that group is active. The hardware does not rank sources against each other. Dispatch software reads the status words to find the cause and decides the service order.

Most sources are level type. Their device has to hold the line until it is serviced, and status simply follows the synchronized level. A chosen subset, set by a parameter and by default sources 0, 1 and 17, is latched. A pulse on one of these lines sets a sticky bit, and the bit stays set until software writes to that source's own end-of-interrupt word. Every input passes through a two-stage synchronizer before it reaches status or the outputs. A small register-bus slave gives read access to status and mask, write access to mask, and a write-only end-of-interrupt word for each source.

Top module: `irq_group_ctrl`

## Requirements
- R1: Sources 0 to 16 belong to the normal group and drive only `irq_n_o`. Sources 17 to 21 belong to the fast group and drive only `fiq_n_o`.
- R2: Each output is active low. It is 0 when at least one enabled, active source of its group exists, and 1 otherwise. It is a plain OR over the group, so it stays low while any one such source remains active.
- R3: The normal mask sits at word address 2, bits 0 to 16. The fast mask sits at word address 3, bits 0 to 4. Both reset to zero. A clear mask bit keeps its source off the output. Unused mask bits are not stored and read as zero.
- R4: Normal status reads at word address 0, in bits 0 to 16, and fast status reads at word address 1, in bits 0 to 4, where fast source 17+k is bit k. Unused bits read as zero. Status shows active sources whatever the mask holds, and a read changes no state.
- R5: A level-type source is not latched. Its status bit and its share of the output follow the synchronized input, and they clear once the input drops.
- R6: A latched-type source (by default 0, 1 and 17) keeps its status bit set after its input falls, however long it waits.
- R7: A write to word address 32+i clears the latch of source i only, whatever data is written. Writing the end-of-interrupt word of a level source, or of a latch that is not set, changes no status.
- R8: If a latched source's synchronized input is still high in the same cycle that its end-of-interrupt write takes effect, the set wins and the latch stays set.
- R9: An input change made before clock edge k is not visible in status or outputs after edge k. It is visible after edge k+1, which is two edges of synchronizer latency.
- R10: While reset is held and right after it, both outputs are high and both status words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 22 | Raw interrupt lines, asynchronous |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the strobe |
| irq_n_o | output | 1 | Normal request, active low |
| fiq_n_o | output | 1 | Fast request, active low |

## Verification
A source change made at a falling edge shows in status and the outputs after exactly two rising edges. The bench therefore reads once after one rising edge and expects the old value, then reads again after the second edge and expects the new one. Mask and end-of-interrupt writes take effect at the single rising edge inside the write, so checks that follow a write are made at the next falling edge. Reads are combinational and are sampled one nanosecond after a falling edge. For the set-wins case, the end-of-interrupt write is timed to land on the exact edge where the synchronized level is still high for its last cycle.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  // word addresses of the register-bus slave
  localparam int unsigned ADR_STAT_N   = 0;
  localparam int unsigned ADR_STAT_F   = 1;
  localparam int unsigned ADR_MASK_N   = 2;
  localparam int unsigned ADR_MASK_F   = 3;
  localparam int unsigned ADR_EOI_BASE = 32;

  // active-high group request: any enabled, active source
  function automatic logic grp_request(input logic [31:0] act, input logic [31:0] en);
    return |(act & en);
  endfunction

  // end-of-interrupt word address of global source idx
  function automatic int unsigned eoi_word(input int unsigned idx);
    return ADR_EOI_BASE + idx;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
  parameter bit LATCHED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic act_o
);
  logic lat_q;
  logic lat_d;
  logic clr_evt;

  assign clr_evt = clr_i;

  // the set term is ORed after the clear, so a set in the same cycle wins
  always_comb lat_d = LATCHED ? ((lat_q & ~clr_evt) | lvl_i) : 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat_q <= 1'b0;
    else        lat_q <= lat_d;

  assign act_o = LATCHED ? (lat_q | lvl_i) : lvl_i;

  if (LATCHED) begin : g_chk
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q && !clr_evt) |=> lat_q);
    // R7
    eoi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q && clr_evt && !lvl_i) |=> !lat_q);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_i |=> lat_q);
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_grp_pkg::*;
#(
  parameter int unsigned N_NORM = 17,
  parameter int unsigned N_FAST = 5,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NSRC  = N_NORM + N_FAST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_NORM-1:0] stat_n_i,
  input  logic [N_FAST-1:0] stat_f_i,
  output logic [N_NORM-1:0] mask_n_o,
  output logic [N_FAST-1:0] mask_f_o,
  output logic [NSRC-1:0]   eoi_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_evt;
  logic rd_evt;
  logic [N_NORM-1:0] mask_n_q;
  logic [N_FAST-1:0] mask_f_q;
  logic unused_wbits;

  assign wr_evt = sel_i && wr_i;
  assign rd_evt = sel_i && !wr_i;
  assign unused_wbits = ^wdata_i[DATA_W-1:N_NORM];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask_n_q <= '0;
      mask_f_q <= '0;
    end else if (wr_evt) begin
      if (addr_i == ADDR_W'(ADR_MASK_N)) mask_n_q <= wdata_i[N_NORM-1:0];
      if (addr_i == ADDR_W'(ADR_MASK_F)) mask_f_q <= wdata_i[N_FAST-1:0];
    end

  for (genvar i = 0; i < NSRC; i++) begin : g_eoi
    assign eoi_o[i] = wr_evt && (addr_i == ADDR_W'(eoi_word(i)));
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(ADR_STAT_N): rdata_o = DATA_W'(stat_n_i);
      ADDR_W'(ADR_STAT_F): rdata_o = DATA_W'(stat_f_i);
      ADDR_W'(ADR_MASK_N): rdata_o = DATA_W'(mask_n_q);
      ADDR_W'(ADR_MASK_F): rdata_o = DATA_W'(mask_f_q);
      default:             rdata_o = '0;
    endcase
  end

  assign mask_n_o = mask_n_q;
  assign mask_f_o = mask_f_q;

  // R4
  read_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> ($stable(mask_n_q) && $stable(mask_f_q)));
  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> ($stable(mask_n_q) && $stable(mask_f_q)));
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_grp_pkg::*;
#(
  parameter int unsigned N_NORM      = 17,
  parameter int unsigned N_FAST      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 32,
  parameter logic [N_NORM+N_FAST-1:0] LATCH_MAP = 22'h02_0003
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_NORM+N_FAST-1:0] src_i,
  input  logic                     bus_sel_i,
  input  logic                     bus_wr_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  output logic                     irq_n_o,
  output logic                     fiq_n_o
);
  localparam int unsigned NSRC = N_NORM + N_FAST;

  logic [NSRC-1:0]   src_s;
  logic [NSRC-1:0]   act;
  logic [NSRC-1:0]   eoi;
  logic [N_NORM-1:0] act_n;
  logic [N_FAST-1:0] act_f;
  logic [N_NORM-1:0] mask_n;
  logic [N_FAST-1:0] mask_f;
  logic              norm_req;
  logic              fast_req;

  irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (src_i),
    .q_o  (src_s)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irq_src_cell #(.LATCHED(LATCH_MAP[i])) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl_i(src_s[i]),
      .clr_i(eoi[i]),
      .act_o(act[i])
    );
  end

  assign act_n = act[N_NORM-1:0];
  assign act_f = act[NSRC-1:N_NORM];

  irq_regs #(.N_NORM(N_NORM), .N_FAST(N_FAST), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .stat_n_i(act_n),
    .stat_f_i(act_f),
    .mask_n_o(mask_n),
    .mask_f_o(mask_f),
    .eoi_o   (eoi),
    .rdata_o (bus_rdata_o)
  );

  assign norm_req = grp_request(32'(act_n), 32'(mask_n));
  assign fast_req = grp_request(32'(act_f), 32'(mask_f));
  assign irq_n_o  = ~norm_req;
  assign fiq_n_o  = ~fast_req;

  // R3
  norm_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_n == '0) |-> irq_n_o);
  // R3
  fast_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_f == '0) |-> fiq_n_o);
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == '0) |-> (irq_n_o && fiq_n_o));
  // R1
  fast_no_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_n == '0) |-> irq_n_o);
endmodule

// File: tb/irq_group_ctrl_tb.sv
`timescale 1ns/1ps
module irq_group_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] src = '0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;
  logic        fiq_n;

  always #2.5 clk = ~clk;

  irq_group_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_n_o(irq_n), .fiq_n_o(fiq_n)
  );

  typedef struct {
    int          kind;   // 0 bus read, 1 irq_n pin, 2 fiq_n pin
    logic [5:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  event  mon_ev;
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  // monitor: pops expected items and compares against the design
  initial forever begin
    @(mon_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = 32'(irq_n);
        default: act = 32'(fiq_n);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d addr %0d: got %h expected %h", it.tag, it.kind, it.a, act, it.exp);
      end
    end
  end

  // driver tasks
  task automatic exp_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    it.kind = 0; it.a = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #0.5;
    sel = 1'b0;
  endtask

  task automatic exp_pin(input int k, input logic e, input string tag);
    item_t it;
    #1;
    it.kind = k; it.a = '0; it.exp = 32'(e); it.tag = tag;
    q.push_back(it);
    -> mon_ev;
    #0.5;
  endtask

  // caller stands at a falling edge; write applies at the next rising edge
  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: during reset
    exp_pin(1, 1'b1, "R10 irq_n in reset");
    exp_pin(2, 1'b1, "R10 fiq_n in reset");
    @(negedge clk) rst_n = 1'b1;
    exp_rd(0, 32'h0, "R10 status normal");
    exp_rd(1, 32'h0, "R10 status fast");
    exp_rd(2, 32'h0, "R3 mask normal reset");
    exp_rd(3, 32'h0, "R3 mask fast reset");

    // R3: active level source blocked by clear mask
    @(negedge clk) src[5] = 1'b1;
    repeat (2) @(negedge clk);
    exp_rd(0, 32'h20, "R4 status ignores mask");
    exp_pin(1, 1'b1, "R3 masked source blocked");

    @(negedge clk);
    wr_reg(2, 32'hFFFF_FFFF);
    exp_rd(2, 32'h0001_FFFF, "R3 unused mask bits zero");
    exp_pin(1, 1'b0, "R2 enabled source drives low");
    @(negedge clk);
    wr_reg(2, 32'h20);

    // R9: latency of two edges
    src[6] = 1'b1;
    @(negedge clk);
    exp_rd(0, 32'h20, "R9 not visible after one edge");
    @(negedge clk);
    exp_rd(0, 32'h60, "R9 visible after two edges");
    exp_rd(0, 32'h60, "R4 second read unchanged");
    exp_rd(2, 32'h20, "R4 mask unchanged by reads");

    // R2: plain OR
    @(negedge clk);
    wr_reg(2, 32'h60);
    src[5] = 1'b0;
    repeat (2) @(negedge clk);
    exp_pin(1, 1'b0, "R2 one source still holds output low");
    @(negedge clk) src[6] = 1'b0;
    repeat (2) @(negedge clk);
    exp_pin(1, 1'b1, "R5 output releases after input drops");
    exp_rd(0, 32'h0, "R5 level status clears");

    // R1: fast group
    @(negedge clk);
    wr_reg(3, 32'h1F);
    src[19] = 1'b1;
    repeat (2) @(negedge clk);
    exp_pin(2, 1'b0, "R1 fast source drives fiq_n");
    exp_pin(1, 1'b1, "R1 fast source leaves irq_n");
    exp_rd(1, 32'h4, "R4 fast status bit position");
    exp_rd(0, 32'h0, "R1 normal status untouched");
    @(negedge clk) src[19] = 1'b0;
    repeat (2) @(negedge clk);
    exp_pin(2, 1'b1, "R5 fast level releases");

    // R6: latch persistence
    @(negedge clk);
    wr_reg(2, 32'h1);
    src[0] = 1'b1;
    @(negedge clk) src[0] = 1'b0;
    repeat (3) @(negedge clk);
    exp_rd(0, 32'h1, "R6 latched after pulse");
    exp_pin(1, 1'b0, "R6 latched source drives output");
    repeat (5) @(negedge clk);
    exp_rd(0, 32'h1, "R6 latch persists");

    // R7: clearing only the addressed latch
    @(negedge clk);
    wr_reg(33, 32'h0);
    wr_reg(37, 32'h0);
    exp_rd(0, 32'h1, "R7 other eoi words no effect");
    @(negedge clk);
    wr_reg(32, 32'hDEAD_BEEF);
    exp_rd(0, 32'h0, "R7 eoi clears latch");
    exp_pin(1, 1'b1, "R7 output released by eoi");

    @(negedge clk) src[1:0] = 2'b11;
    @(negedge clk) src[1:0] = 2'b00;
    repeat (3) @(negedge clk);
    exp_rd(0, 32'h3, "R6 two latches set");
    @(negedge clk);
    wr_reg(33, 32'h0);
    exp_rd(0, 32'h1, "R7 only source 1 cleared");
    @(negedge clk);
    wr_reg(32, 32'h0);
    exp_rd(0, 32'h0, "R7 source 0 cleared");

    // R8: set wins on the last high cycle
    @(negedge clk) src[0] = 1'b1;
    repeat (3) @(negedge clk);
    src[0] = 1'b0;
    @(negedge clk);
    wr_reg(32, 32'h0);
    repeat (2) @(negedge clk);
    exp_rd(0, 32'h1, "R8 set wins over eoi");
    @(negedge clk);
    wr_reg(32, 32'h0);
    exp_rd(0, 32'h0, "R8 later eoi clears");

    // fast latched source 17
    @(negedge clk) src[17] = 1'b1;
    @(negedge clk) src[17] = 1'b0;
    repeat (3) @(negedge clk);
    exp_rd(1, 32'h1, "R6 fast latch set");
    exp_pin(2, 1'b0, "R1 fast latch drives fiq_n");
    @(negedge clk);
    wr_reg(49, 32'h0);
    exp_rd(1, 32'h0, "R7 fast eoi clears");
    exp_pin(2, 1'b1, "R7 fiq_n released");

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule